// File: doc/BRIEF.md
# SDRAM Initialisation and Refresh Sequencer

This block owns every refresh-related command an SDRAM controller must emit. After reset it holds the device idle for a power-up pause. It then runs a two-refresh wake-up and only afterwards declares the memory ready. In normal operation it paces auto-refresh commands evenly. Each refresh is raised as a pending request to the controller's arbiter, and the command is issued only once the arbiter grants the slot. The caller reports whether any bank may still be open. If so, a precharge-all is placed in front of the refresh.

On request the block puts the SDRAM into self refresh by issuing the refresh command with CKE low, and holds CKE low for at least the minimum dwell. It waits for a stable clock before raising CKE again. It then emits a NOP window and a catch-up refresh before normal operation resumes. If an auto-refresh slips past its deadline, a one-cycle miss flag is raised and ready is withdrawn. The two-refresh wake-up is then repeated.

All timing values are parameters in clock cycles, so a bench can use scaled values: the power-up pause, refresh spacing, deadline slack, row cycle time, minimum self-refresh dwell and exit NOP window.

Top module: `sdram_refresh_seq`

## Requirements
- R1: Command encoding on `cmd`: 2'b00 NOP, 2'b01 precharge-all, 2'b10 auto-refresh. During reset and for the first PWRUP_CYC cycles after reset release, `cmd` is NOP, `cke` is high, and `ready` and `ref_pending` are low. `ref_pending` rises in cycle PWRUP_CYC.
- R2: After the pause, two auto-refreshes are issued. `ready` stays low until exactly TRC_CYC cycles after the second of them, when it rises.
- R3: Two auto-refresh commands are never less than TRC_CYC cycles apart.
- R4: `ref_pending` stays high until `ref_grant` is seen. With banks closed, the auto-refresh appears in the cycle after the grant is sampled.
- R5: If `banks_open` is high when the grant is taken, a one-cycle precharge-all is issued and the auto-refresh follows in the next cycle.
- R6: While ready, with the grant always given and banks closed, consecutive auto-refreshes are exactly REF_GAP cycles apart, and `ready` stays high.
- R7: If no auto-refresh is issued within REF_GAP+MISS_LIMIT cycles of the previous one, `deadline_miss` pulses for one cycle at that offset. `ready` falls in the next cycle, and rises again only TRC_CYC cycles after the second of two new auto-refreshes.
- R8: A `sr_req` seen while ready and idle enters self refresh in the next cycle. The entry is an auto-refresh with `cke` low, preceded by a one-cycle precharge-all with `cke` high when `banks_open` is high. `ready` is low from the first of these cycles.
- R9: `cke` stays low for at least TRAS_CYC cycles, counting the entry cycle, even if exit is requested at once. With a stable clock and an early exit request it is exactly TRAS_CYC cycles.
- R10: A one-cycle `sr_exit` pulse is remembered. `cke` stays low while `clk_stable` is low, and rises in the cycle after `clk_stable` is seen high.
- R11: After `cke` rises, NOP is issued for max(TXSR_CYC,2) cycles with `ref_pending` low. Then one catch-up auto-refresh is requested, and `ready` rises TRC_CYC cycles after it.
- R12: `sr_req` has no effect outside the ready idle state; for example, during the power-up pause `cke` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_grant | input | 1 | Arbiter grants the pending refresh slot |
| banks_open | input | 1 | Some bank may be open; precharge-all first |
| sr_req | input | 1 | Request to enter self refresh |
| sr_exit | input | 1 | Request to leave self refresh (pulse is remembered) |
| clk_stable | input | 1 | Clock is stable; CKE may rise |
| ref_pending | output | 1 | A refresh is waiting for a grant |
| cmd | output | 2 | SDRAM command (encoding in R1) |
| cke | output | 1 | Clock enable to the SDRAM |
| ready | output | 1 | Memory initialised and usable |
| deadline_miss | output | 1 | One-cycle flag: refresh deadline passed |

## Verification
The bench uses short scaled timings and aims at the cycle boundaries. It checks the exact cycle `ref_pending` first rises after the pause; an off-by-one timer would move it. It checks the exact spacing of paced refreshes, and the exact cycle of the miss flag when the grant is withheld. A design that resumed after one refresh, or skipped the repeat wake-up, would show `ready` too early. It requests exit during the entry cycle to prove the dwell is enforced. It sets the exit NOP parameter to one to prove the two-cycle floor. It pulses exit while the clock is unstable, so that a design raising CKE early, or forgetting the pulse, is caught.

// File: rtl/sdram_rs_pkg.sv
// Shared types for the SDRAM init/refresh sequencer.
package sdram_rs_pkg;

    // Command encoding on the cmd port.
    typedef enum logic [1:0] {
        CMD_NOP  = 2'b00,
        CMD_PALL = 2'b01,
        CMD_AREF = 2'b10
    } sdram_cmd_e;

    // Sequencer states.
    typedef enum logic [3:0] {
        ST_PWR,     // power-up pause
        ST_REQ,     // refresh pending, waiting for grant
        ST_PRE,     // precharge-all before refresh
        ST_REF,     // auto-refresh command
        ST_TRC,     // row cycle wait after refresh
        ST_IDLE,    // ready, nothing due
        ST_SR_PRE,  // precharge-all before self refresh
        ST_SR_ENT,  // refresh command with CKE low
        ST_SR,      // self-refresh dwell
        ST_XSR      // CKE high, NOP exit window
    } seq_state_e;

endpackage

// File: rtl/sdram_rs_pacer.sv
// Refresh pacing counter.
// Counts cycles since the last auto-refresh. It flags "due" so that, with an
// immediate grant, refreshes land exactly REF_GAP cycles apart. It flags
// "overdue" once REF_GAP+MISS_LIMIT cycles pass without one.
// Assumes REF_GAP >= 4 and MISS_LIMIT >= 1.
module sdram_rs_pacer #(
    parameter int REF_GAP    = 780,
    parameter int MISS_LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    output logic due,
    output logic overdue
);
    localparam int LIM = REF_GAP + MISS_LIMIT - 1;
    localparam int CW  = $clog2(LIM + 1);

    logic [CW-1:0] cnt;

    // Cycle counter since last refresh, held at zero while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !en) begin
            cnt <= '0;
        end else if (cnt != CW'(LIM)) begin
            cnt <= cnt + CW'(1);
        end
    end

    // Thresholds: due two cycles ahead of the slot, overdue at the deadline.
    always_comb begin
        due     = (cnt >= CW'(REF_GAP - 3));
        overdue = (cnt >= CW'(LIM));
    end

endmodule

// File: rtl/sdram_rs_fsm.sv
// Sequencer state machine for power-up, refresh and self refresh.
// One shared down-counter times the pause, row cycle, dwell and exit window.
// refs_left holds how many refreshes are still owed before ready.
// Assumes TRC_CYC >= 2, TRAS_CYC >= 2 and REF_GAP >= TRC_CYC + 2 at the top.
module sdram_rs_fsm
    import sdram_rs_pkg::*;
#(
    parameter int PWRUP_CYC = 10000000,
    parameter int TRC_CYC   = 7,
    parameter int TRAS_CYC  = 5,
    parameter int TXSR_CYC  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       due,
    input  logic       overdue,
    input  logic       ref_grant,
    input  logic       banks_open,
    input  logic       sr_req,
    input  logic       sr_exit,
    input  logic       clk_stable,
    output logic [1:0] cmd,
    output logic       cke,
    output logic       ready,
    output logic       ref_pending,
    output logic       deadline_miss,
    output logic       pace_en,
    output logic       pace_clr
);
    localparam int XSR_N = (TXSR_CYC < 2) ? 2 : TXSR_CYC;
    localparam int MAX_A = (PWRUP_CYC > TRC_CYC) ? PWRUP_CYC : TRC_CYC;
    localparam int MAX_B = (TRAS_CYC > XSR_N) ? TRAS_CYC : XSR_N;
    localparam int MAXT  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int TW    = $clog2(MAXT + 1);

    seq_state_e    state;
    logic [TW-1:0] tcnt;
    logic [1:0]    refs_left;
    logic          ready_q;
    logic          exit_pend;

    // State transitions, shared timer, refresh debt and exit latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_PWR;
            tcnt      <= TW'(PWRUP_CYC - 1);
            refs_left <= 2'd2;
            ready_q   <= 1'b0;
            exit_pend <= 1'b0;
        end else begin
            unique case (state)
                ST_PWR: begin
                    if (tcnt == '0) state <= ST_REQ;
                    else            tcnt  <= tcnt - TW'(1);
                end
                ST_REQ: begin
                    if (overdue) begin
                        refs_left <= 2'd2;
                        ready_q   <= 1'b0;
                    end
                    if (ref_grant) state <= banks_open ? ST_PRE : ST_REF;
                end
                ST_PRE: state <= ST_REF;
                ST_REF: begin
                    state <= ST_TRC;
                    tcnt  <= TW'(TRC_CYC - 2);
                end
                ST_TRC: begin
                    if (tcnt != '0) begin
                        tcnt <= tcnt - TW'(1);
                    end else if (refs_left <= 2'd1) begin
                        state     <= ST_IDLE;
                        ready_q   <= 1'b1;
                        refs_left <= 2'd1;
                    end else begin
                        refs_left <= refs_left - 2'd1;
                        state     <= ST_REQ;
                    end
                end
                ST_IDLE: begin
                    if (sr_req) begin
                        ready_q   <= 1'b0;
                        exit_pend <= 1'b0;
                        state     <= banks_open ? ST_SR_PRE : ST_SR_ENT;
                    end else if (due) begin
                        state <= ST_REQ;
                    end
                end
                ST_SR_PRE: begin
                    exit_pend <= exit_pend | sr_exit;
                    state     <= ST_SR_ENT;
                end
                ST_SR_ENT: begin
                    exit_pend <= exit_pend | sr_exit;
                    tcnt      <= TW'(TRAS_CYC - 2);
                    state     <= ST_SR;
                end
                ST_SR: begin
                    if (tcnt != '0) tcnt <= tcnt - TW'(1);
                    if (tcnt == '0 && (exit_pend || sr_exit) && clk_stable) begin
                        state     <= ST_XSR;
                        tcnt      <= TW'(XSR_N - 1);
                        exit_pend <= 1'b0;
                    end else begin
                        exit_pend <= exit_pend | sr_exit;
                    end
                end
                ST_XSR: begin
                    if (tcnt == '0) begin
                        state     <= ST_REQ;
                        refs_left <= 2'd1;
                    end else begin
                        tcnt <= tcnt - TW'(1);
                    end
                end
                default: state <= ST_PWR;
            endcase
        end
    end

    // Moore outputs decoded from the state register.
    always_comb begin
        unique case (state)
            ST_PRE, ST_SR_PRE: cmd = CMD_PALL;
            ST_REF, ST_SR_ENT: cmd = CMD_AREF;
            default:           cmd = CMD_NOP;
        endcase
        cke           = !(state == ST_SR_ENT || state == ST_SR);
        ref_pending   = (state == ST_REQ);
        deadline_miss = (state == ST_REQ) && overdue;
        pace_en       = (state == ST_REQ) || (state == ST_PRE) || (state == ST_REF) ||
                        (state == ST_TRC) || (state == ST_IDLE);
        pace_clr      = (state == ST_REF) || deadline_miss;
        ready         = ready_q;
    end

endmodule

// File: rtl/sdram_refresh_seq.sv
// SDRAM initialisation and refresh sequencer (top).
// Combines the pacing counter and the sequence FSM. All timings are in clock
// cycles. Assumes the arbiter keeps read/write traffic off the bus whenever a
// refresh or precharge-all command is issued.
module sdram_refresh_seq
    import sdram_rs_pkg::*;
#(
    parameter int PWRUP_CYC  = 10000000,
    parameter int REF_GAP    = 780,
    parameter int MISS_LIMIT = 64,
    parameter int TRC_CYC    = 7,
    parameter int TRAS_CYC   = 5,
    parameter int TXSR_CYC   = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_grant,
    input  logic       banks_open,
    input  logic       sr_req,
    input  logic       sr_exit,
    input  logic       clk_stable,
    output logic       ref_pending,
    output logic [1:0] cmd,
    output logic       cke,
    output logic       ready,
    output logic       deadline_miss
);
    logic due, overdue, pace_en, pace_clr;

    sdram_rs_pacer #(
        .REF_GAP    (REF_GAP),
        .MISS_LIMIT (MISS_LIMIT)
    ) u_pacer (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (pace_en),
        .clr     (pace_clr),
        .due     (due),
        .overdue (overdue)
    );

    sdram_rs_fsm #(
        .PWRUP_CYC (PWRUP_CYC),
        .TRC_CYC   (TRC_CYC),
        .TRAS_CYC  (TRAS_CYC),
        .TXSR_CYC  (TXSR_CYC)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .due           (due),
        .overdue       (overdue),
        .ref_grant     (ref_grant),
        .banks_open    (banks_open),
        .sr_req        (sr_req),
        .sr_exit       (sr_exit),
        .clk_stable    (clk_stable),
        .cmd           (cmd),
        .cke           (cke),
        .ready         (ready),
        .ref_pending   (ref_pending),
        .deadline_miss (deadline_miss),
        .pace_en       (pace_en),
        .pace_clr      (pace_clr)
    );

endmodule

// File: rtl/sdram_refresh_seq_chk.sv
// Protocol checker for the refresh sequencer, bound to the top module.
// Watches only the top-level ports; small counters cover timing windows.
module sdram_refresh_seq_chk
    import sdram_rs_pkg::*;
#(
    parameter int TRC_CYC  = 7,
    parameter int TRAS_CYC = 5
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ref_grant,
    input logic       clk_stable,
    input logic       ref_pending,
    input logic [1:0] cmd,
    input logic       cke,
    input logic       ready,
    input logic       deadline_miss
);
    localparam int GW = $clog2(TRC_CYC + 1);
    localparam int LW = $clog2(TRAS_CYC + 1);

    logic [GW-1:0] gap;
    logic [LW-1:0] low_run;

    // Cycles since the previous refresh command, saturating at TRC_CYC.
    always_ff @(posedge clk) begin
        if (!rst_n)                     gap <= GW'(TRC_CYC);
        else if (cmd == CMD_AREF)       gap <= GW'(1);
        else if (gap != GW'(TRC_CYC))   gap <= gap + GW'(1);
    end

    // Consecutive CKE-low cycles, saturating at TRAS_CYC.
    always_ff @(posedge clk) begin
        if (!rst_n || cke)               low_run <= '0;
        else if (low_run != LW'(TRAS_CYC)) low_run <= low_run + LW'(1);
    end

    a_r1_cmd_legal: assert property (@(posedge clk) disable iff (!rst_n)
        cmd != 2'b11);
    a_r3_trc_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_AREF |-> gap >= GW'(TRC_CYC));
    a_r4_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pending && !ref_grant |=> ref_pending);
    a_r5_pall_then_aref: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_PALL |=> cmd == CMD_AREF);
    a_r7_miss_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        deadline_miss |=> !ready);
    a_r8_entry_is_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> cmd == CMD_AREF);
    a_r8_not_ready_in_sr: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> !ready);
    a_r9_dwell: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> low_run >= LW'(TRAS_CYC));
    a_r10_stable_clock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> $past(clk_stable));
    a_r11_nop_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> cmd == CMD_NOP);
    a_r11_nop_second: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |=> cke && cmd == CMD_NOP);

endmodule

bind sdram_refresh_seq sdram_refresh_seq_chk #(
    .TRC_CYC  (TRC_CYC),
    .TRAS_CYC (TRAS_CYC)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ref_grant     (ref_grant),
    .clk_stable    (clk_stable),
    .ref_pending   (ref_pending),
    .cmd           (cmd),
    .cke           (cke),
    .ready         (ready),
    .deadline_miss (deadline_miss)
);

// File: tb/sdram_refresh_seq_tb.sv
// Directed bench for the refresh sequencer, with scaled timings.
module sdram_refresh_seq_tb;
    localparam int P    = 20;
    localparam int G    = 30;
    localparam int M    = 12;
    localparam int TRC  = 4;
    localparam int TRAS = 6;
    localparam int TXSR = 1;
    localparam int XSRN = 2;
    localparam logic [1:0] C_NOP  = 2'b00;
    localparam logic [1:0] C_PALL = 2'b01;
    localparam logic [1:0] C_AREF = 2'b10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ref_grant = 1'b0, banks_open = 1'b0, sr_req = 1'b0, sr_exit = 1'b0;
    logic clk_stable = 1'b1;
    logic ref_pending, cke, ready, deadline_miss;
    logic [1:0] cmd;

    int cyc = 0, checks = 0, fails = 0, last_aref = 0, ready_low_seen = 0;
    bit done = 1'b0;

    sdram_refresh_seq #(
        .PWRUP_CYC (P), .REF_GAP (G), .MISS_LIMIT (M),
        .TRC_CYC (TRC), .TRAS_CYC (TRAS), .TXSR_CYC (TXSR)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .ref_grant (ref_grant), .banks_open (banks_open),
        .sr_req (sr_req), .sr_exit (sr_exit), .clk_stable (clk_stable),
        .ref_pending (ref_pending), .cmd (cmd), .cke (cke), .ready (ready),
        .deadline_miss (deadline_miss)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Step until cmd equals c; records ready-low cycles seen on the way.
    task automatic wait_cmd(input logic [1:0] c, input int lim, output int at);
        bit found = 1'b0;
        int n = 0;
        at = -1;
        while (!found && n < lim) begin
            step();
            n++;
            if (!ready) ready_low_seen++;
            if (cmd == c) begin
                found = 1'b1;
                at = cyc;
            end
        end
    endtask

    task automatic t_powerup();
        int bad = 0, ckelow = 0, a1, a2;
        sr_req = 1'b1;
        repeat (3) step();
        chk(cmd == C_NOP && cke && !ready && !ref_pending, "R1", "reset outputs",
            {cmd, cke, ready, ref_pending}, {C_NOP, 3'b100});
        rst_n = 1'b1;
        for (int k = 0; k < P; k++) begin
            if (cmd != C_NOP || !cke || ready || ref_pending) bad++;
            if (!cke) ckelow++;
            step();
        end
        chk(bad == 0, "R1", "bad cycles during pause", bad, 0);
        chk(ckelow == 0, "R12", "cke low cycles with sr_req in pause", ckelow, 0);
        chk(ref_pending && cyc == P, "R1", "pending after pause", cyc, P);
        sr_req = 1'b0;
        repeat (3) step();
        chk(ref_pending && cmd == C_NOP, "R4", "pending held without grant",
            ref_pending, 1);
        ref_grant = 1'b1;
        step();
        chk(cmd == C_AREF, "R4", "refresh after grant", cmd, C_AREF);
        a1 = cyc;
        wait_cmd(C_AREF, 20, a2);
        chk(a2 - a1 >= TRC, "R3", "wake-up refresh spacing", a2 - a1, TRC);
        for (int i = 1; i <= TRC; i++) begin
            step();
            if (i < TRC) chk(!ready, "R2", "ready early", ready, 0);
            else         chk(ready,  "R2", "ready after wake-up", ready, 1);
        end
        last_aref = a2;
    endtask

    task automatic t_periodic();
        int x1, x2;
        ready_low_seen = 0;
        wait_cmd(C_AREF, 3 * G, x1);
        chk(x1 - last_aref == G, "R6", "first paced spacing", x1 - last_aref, G);
        wait_cmd(C_AREF, 3 * G, x2);
        chk(x2 - x1 == G, "R6", "second paced spacing", x2 - x1, G);
        chk(ready_low_seen == 0, "R6", "ready low cycles", ready_low_seen, 0);
        last_aref = x2;
    endtask

    task automatic t_precharge();
        int p;
        banks_open = 1'b1;
        wait_cmd(C_PALL, 3 * G, p);
        chk(p - last_aref == G, "R5", "precharge slot", p - last_aref, G);
        step();
        chk(cmd == C_AREF, "R5", "refresh after precharge", cmd, C_AREF);
        last_aref = cyc;
        banks_open = 1'b0;
    endtask

    task automatic t_miss();
        int t0 = last_aref, mc = -1, b1, b2, n = 0;
        ref_grant = 1'b0;
        while (mc < 0 && n < 3 * (G + M)) begin
            step();
            n++;
            if (deadline_miss) mc = cyc;
        end
        chk(mc - t0 == G + M, "R7", "miss flag offset", mc - t0, G + M);
        step();
        chk(!ready && !deadline_miss && ref_pending, "R7", "after miss",
            {ready, deadline_miss, ref_pending}, 3'b001);
        ref_grant = 1'b1;
        step();
        chk(cmd == C_AREF && !ready, "R7", "first recovery refresh", cmd, C_AREF);
        b1 = cyc;
        wait_cmd(C_AREF, 20, b2);
        chk(b2 > b1 && !ready, "R7", "second recovery refresh, ready low", ready, 0);
        repeat (TRC) step();
        chk(ready, "R7", "ready back after two refreshes", ready, 1);
        last_aref = b2;
    endtask

    task automatic t_sr_early_exit();
        int t0, lows = 0, n = 0;
        wait_cmd(C_AREF, 3 * G, t0);
        repeat (TRC + 2) step();
        banks_open = 1'b1;
        sr_req = 1'b1;
        step();
        chk(cmd == C_PALL && cke && !ready, "R8", "precharge before entry",
            {cmd, cke, ready}, {C_PALL, 2'b10});
        sr_req = 1'b0;
        step();
        chk(cmd == C_AREF && !cke, "R8", "entry refresh with cke low",
            {cmd, cke}, {C_AREF, 1'b0});
        sr_exit = 1'b1;
        while (!cke && n < 50) begin
            lows++;
            step();
            sr_exit = 1'b0;
            banks_open = 1'b0;
            n++;
        end
        chk(lows == TRAS, "R9", "cke low cycles", lows, TRAS);
        for (int i = 0; i < XSRN; i++) begin
            chk(cke && cmd == C_NOP && !ref_pending, "R11", "exit window NOP",
                {cke, cmd, ref_pending}, {1'b1, C_NOP, 1'b0});
            step();
        end
        chk(ref_pending, "R11", "catch-up pending after window", ref_pending, 1);
        step();
        chk(cmd == C_AREF && !ready, "R11", "catch-up refresh", cmd, C_AREF);
        repeat (TRC - 1) step();
        chk(!ready, "R11", "ready before tRC", ready, 0);
        step();
        chk(ready, "R11", "ready after catch-up", ready, 1);
    endtask

    task automatic t_sr_unstable();
        int t0, n = 0, highs = 0;
        wait_cmd(C_AREF, 3 * G, t0);
        repeat (TRC + 2) step();
        clk_stable = 1'b0;
        sr_req = 1'b1;
        step();
        chk(cmd == C_AREF && !cke, "R8", "direct entry with banks closed",
            {cmd, cke}, {C_AREF, 1'b0});
        sr_req = 1'b0;
        step();
        sr_exit = 1'b1;
        step();
        sr_exit = 1'b0;
        repeat (20) begin
            if (cke) highs++;
            step();
        end
        chk(highs == 0, "R10", "cke high while clock unstable", highs, 0);
        clk_stable = 1'b1;
        step();
        chk(cke, "R10", "cke rises after stable clock", cke, 1);
        while (!ready && n < 40) begin
            step();
            n++;
        end
        chk(ready, "R10", "ready after exit", ready, 1);
    endtask

    initial begin
        t_powerup();
        t_periodic();
        t_precharge();
        t_miss();
        t_sr_early_exit();
        t_sr_unstable();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule